// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Buffered Access

The block is a free-running 16-bit up-counter that software reaches through an 8-bit register bus. The count is split into a low-byte register and a high-byte register. A one-bit access mode in a control register selects how those two bytes behave.

In direct mode every byte access goes straight to the live counter. A carry from the low byte into the high byte can therefore land between two byte reads, and the pair read back may be torn. In buffered mode one shadow byte makes multi-byte access atomic:

- Reading the low byte copies the live high byte into the shadow, and a following high-byte read returns that copy.
- Writing the high byte only fills the shadow. The next low-byte write then loads all sixteen bits in a single cycle.

The counter advances on each clock where `count_en` is high. It emits a one-cycle `wrap_pulse` when it rolls over from all ones to zero. Read data is registered and is presented on the cycle after the read strobe.

Top module: `byte_timer`

## Requirements
- R1: After synchronous reset the counter is 0x0000, the mode is direct, the shadow byte is 0x00, `bus_rdata` is 0x00 and `wrap_pulse` is low.
- R2: On every rising edge where `count_en` is high and no counter write occurs, the count increases by one modulo 65536; with `count_en` low and no write it holds.
- R3: `wrap_pulse` is high for exactly the one cycle following the edge at which the count rolls from 0xFFFF to 0x0000, and low otherwise.
- R4: Address 2 is the control register. Bit 0 is the mode (0 = direct, 1 = buffered). It reads back in bit 0, and bits 7..1 always read as zero.
- R5: A read strobe at address 0 (low byte) or address 1 (high byte, in direct mode) places the live byte as it stood before that edge on `bus_rdata` one cycle later. In direct mode a carry between the two reads is visible, so the bytes may be torn.
- R6: In direct mode a write to address 0 replaces only the low byte, and a write to address 1 replaces only the high byte.
- R7: In buffered mode a low-byte read copies the live high byte into the shadow. A high-byte read returns the shadow, not the live high byte.
- R8: In buffered mode a high-byte write changes only the shadow and leaves the counter untouched. A low-byte write loads the counter with {shadow, written byte} in one cycle.
- R9: In a cycle with a counter write, the counter takes the written value and does not also advance.
- R10: Address 3 is unused. Writes to it change nothing, and reads from it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Registered read data, valid the cycle after `bus_rd` |
| count_en | input | 1 | Advance the count by one on this edge |
| wrap_pulse | output | 1 | One-cycle pulse after a rollover from all ones to zero |

## Verification
Each result has a fixed due cycle:

- Read data is due one cycle after the read strobe.
- A write or count step shows up at the edge where it is sampled.
- `wrap_pulse` rises in the cycle right after the rolling edge.

The bench drives on falling edges. A flag registered on the rising edge marks which cycles carry a read result, and the scoreboard monitor compares queued expectations only on the next falling edge. The overflow pulse is checked on each of four consecutive falling edges around the rollover, so both a missing pulse and a pulse that lasts too long are caught. Torn and atomic reads are provoked by the same count-enabled read pair in each mode, with expected bytes worked out from the number of edges between the reads.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int TMR_BYTE_W = 8;
    localparam int TMR_ADDR_W = 2;

    typedef enum logic [TMR_ADDR_W-1:0] {
        REG_LO  = 2'd0,
        REG_HI  = 2'd1,
        REG_CTL = 2'd2,
        REG_RSV = 2'd3
    } tmr_reg_e;

    typedef enum logic {
        ACC_DIRECT   = 1'b0,
        ACC_BUFFERED = 1'b1
    } tmr_acc_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_ctl;
        logic rd_lo;
        logic rd_hi;
        logic rd_ctl;
        logic rd_rsv;
    } tmr_strobe_t;

    function automatic tmr_strobe_t decode_access(
        input logic [TMR_ADDR_W-1:0] addr,
        input logic                  wr,
        input logic                  rd
    );
        tmr_strobe_t s;
        tmr_reg_e    r;
        r        = tmr_reg_e'(addr);
        s.wr_lo  = wr && (r == REG_LO);
        s.wr_hi  = wr && (r == REG_HI);
        s.wr_ctl = wr && (r == REG_CTL);
        s.rd_lo  = rd && (r == REG_LO);
        s.rd_hi  = rd && (r == REG_HI);
        s.rd_ctl = rd && (r == REG_CTL);
        s.rd_rsv = rd && (r == REG_RSV);
        return s;
    endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import timer_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TMR_ADDR_W-1:0] addr,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [BYTE_W-1:0]     wdata,
    output tmr_strobe_t           strobe,
    output tmr_acc_e              mode
);

    always_comb begin
        strobe = decode_access(addr, wr, rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= ACC_DIRECT;
        end else if (strobe.wr_ctl) begin
            mode <= tmr_acc_e'(wdata[0]);
        end
    end

endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow
    import timer_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_acc_e          mode,
    input  tmr_strobe_t       strobe,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] live_hi,
    output logic [BYTE_W-1:0] shadow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (mode == ACC_BUFFERED) begin
            if (strobe.wr_hi) begin
                shadow <= wdata;
            end else if (strobe.rd_lo) begin
                shadow <= live_hi;
            end
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import timer_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     count_en,
    input  logic [NBYTES-1:0]        lane_ld,
    input  logic [NBYTES*BYTE_W-1:0] lane_val,
    output logic [NBYTES*BYTE_W-1:0] cnt,
    output logic                     wrap
);

    localparam int CW = NBYTES * BYTE_W;

    logic          any_ld;
    logic [CW-1:0] next_ld;
    logic [CW-1:0] cnt_inc;

    assign any_ld  = |lane_ld;
    assign cnt_inc = cnt + CW'(1);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign next_ld[g*BYTE_W +: BYTE_W] =
            lane_ld[g] ? lane_val[g*BYTE_W +: BYTE_W] : cnt[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (any_ld) begin
                cnt <= next_ld;
            end else if (count_en) begin
                cnt  <= cnt_inc;
                wrap <= &cnt;
            end
        end
    end

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import timer_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_strobe_t       strobe,
    input  tmr_acc_e          mode,
    input  logic [BYTE_W-1:0] live_lo,
    input  logic [BYTE_W-1:0] live_hi,
    input  logic [BYTE_W-1:0] shadow,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] sel;
    logic              any_rd;

    assign any_rd = strobe.rd_lo | strobe.rd_hi | strobe.rd_ctl | strobe.rd_rsv;

    always_comb begin
        sel = '0;
        if (strobe.rd_lo) begin
            sel = live_lo;
        end else if (strobe.rd_hi) begin
            sel = (mode == ACC_BUFFERED) ? shadow : live_hi;
        end else if (strobe.rd_ctl) begin
            sel    = '0;
            sel[0] = mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (any_rd) begin
            rdata <= sel;
        end
    end

endmodule

// File: rtl/byte_timer.sv
module byte_timer
    import timer_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TMR_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic                  count_en,
    output logic                  wrap_pulse
);

    localparam int NBYTES = 2;
    localparam int CW     = NBYTES * BYTE_W;

    tmr_strobe_t       strobe;
    tmr_acc_e          mode;
    logic [BYTE_W-1:0] shadow;
    logic [CW-1:0]     cnt_q;
    logic [NBYTES-1:0] lane_ld;
    logic [CW-1:0]     lane_val;
    logic              cnt_wr;

    tmr_regif #(.BYTE_W(BYTE_W)) u_regif (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wdata  (bus_wdata),
        .strobe (strobe),
        .mode   (mode)
    );

    tmr_shadow #(.BYTE_W(BYTE_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .strobe  (strobe),
        .wdata   (bus_wdata),
        .live_hi (cnt_q[CW-1 -: BYTE_W]),
        .shadow  (shadow)
    );

    always_comb begin
        lane_ld[0]             = strobe.wr_lo;
        lane_val[BYTE_W-1:0]   = bus_wdata;
        if (mode == ACC_BUFFERED) begin
            lane_ld[1]             = strobe.wr_lo;
            lane_val[CW-1 -: BYTE_W] = shadow;
        end else begin
            lane_ld[1]             = strobe.wr_hi;
            lane_val[CW-1 -: BYTE_W] = bus_wdata;
        end
    end

    assign cnt_wr = |lane_ld;

    tmr_core #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_core (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .lane_ld  (lane_ld),
        .lane_val (lane_val),
        .cnt      (cnt_q),
        .wrap     (wrap_pulse)
    );

    tmr_rdmux #(.BYTE_W(BYTE_W)) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .mode    (mode),
        .live_lo (cnt_q[BYTE_W-1:0]),
        .live_hi (cnt_q[CW-1 -: BYTE_W]),
        .shadow  (shadow),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/byte_timer_chk.sv
module byte_timer_chk
    import timer_pkg::*;
#(
    parameter int BYTE_W = TMR_BYTE_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic [TMR_ADDR_W-1:0] bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [BYTE_W-1:0]     bus_wdata,
    input logic [BYTE_W-1:0]     bus_rdata,
    input logic                  count_en,
    input logic                  wrap_pulse,
    input logic [2*BYTE_W-1:0]   cnt,
    input logic [BYTE_W-1:0]     shadow,
    input tmr_acc_e              mode,
    input logic                  cnt_wr
);

    localparam int CW = 2 * BYTE_W;

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && !cnt_wr) |=> (cnt == CW'($past(cnt) + CW'(1))));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !cnt_wr) |=> $stable(cnt));

    // R3
    wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse);

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (cnt == '0));

    // R5
    lo_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0) |=> (bus_rdata == $past(cnt[BYTE_W-1:0])));

    // R7
    shadow_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == ACC_BUFFERED && bus_rd && bus_addr == 2'd0 && !(bus_wr && bus_addr == 2'd1))
        |=> (shadow == $past(cnt[CW-1 -: BYTE_W])));

    // R8
    shadow_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == ACC_BUFFERED && bus_wr && bus_addr == 2'd1 && !count_en)
        |=> (shadow == $past(bus_wdata)) && $stable(cnt));

    // R10
    rsv_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == '0));

endmodule

bind byte_timer byte_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .count_en   (count_en),
    .wrap_pulse (wrap_pulse),
    .cnt        (cnt_q),
    .shadow     (shadow),
    .mode       (mode),
    .cnt_wr     (cnt_wr)
);

// File: tb/byte_timer_test.sv
module byte_timer_test;
    import timer_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       count_en;
    logic       wrap_pulse;

    always #10 clk = ~clk;

    byte_timer #(.BYTE_W(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .count_en   (count_en),
        .wrap_pulse (wrap_pulse)
    );

    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    bit         done   = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    // monitor: read data is due one cycle after the strobe
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        logic [7:0] e;
        string      t;
        if (rd_seen && !rst) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL scoreboard: unexpected read result %h expected none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // driver tasks: each is entered just after a falling edge
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic chk_bit(input string t, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: value=%b expected %b", t, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; count_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_bit("R1 wrap after reset", wrap_pulse, 1'b0);
        chk_bit("R1 rdata after reset", |bus_rdata, 1'b0);
        rd(REG_LO,  8'h00, "R1 low byte after reset");
        rd(REG_HI,  8'h00, "R1 high byte after reset");
        rd(REG_CTL, 8'h00, "R1 mode direct after reset");

        // direct byte writes
        wr(REG_LO, 8'h34);
        wr(REG_HI, 8'h12);
        rd(REG_LO, 8'h34, "R6 direct low write");
        rd(REG_HI, 8'h12, "R6 direct high write");
        wr(REG_HI, 8'h9C);
        rd(REG_LO, 8'h34, "R6 high write keeps low byte");

        // counting 3 edges from 0x00FE
        wr(REG_LO, 8'hFE);
        wr(REG_HI, 8'h00);
        count_en = 1'b1;
        idle(3);
        count_en = 1'b0;
        rd(REG_LO, 8'h01, "R2 low after three steps");
        rd(REG_HI, 8'h01, "R2 carry into high byte");
        idle(5);
        rd(REG_LO, 8'h01, "R2 hold with count disabled");

        // torn pair in direct mode
        wr(REG_LO, 8'hFF);
        wr(REG_HI, 8'h00);
        count_en = 1'b1;
        rd(REG_LO, 8'hFF, "R5 direct low read");
        rd(REG_HI, 8'h01, "R5 direct high read sees carry (torn)");
        count_en = 1'b0;

        // control register
        wr(REG_CTL, 8'hFF);
        rd(REG_CTL, 8'h01, "R4 mode bit set, upper bits zero");

        // atomic pair in buffered mode
        wr(REG_HI, 8'h00);
        wr(REG_LO, 8'hFF);
        count_en = 1'b1;
        rd(REG_LO, 8'hFF, "R7 buffered low read");
        rd(REG_HI, 8'h00, "R7 high read returns shadow not live");
        count_en = 1'b0;

        // high write goes to shadow only
        wr(REG_HI, 8'hAB);
        rd(REG_LO, 8'h01, "R8 low unchanged by high write");
        rd(REG_HI, 8'h01, "R8 live high unchanged by high write");
        wr(REG_HI, 8'hC3);
        wr(REG_LO, 8'h5A);
        rd(REG_LO, 8'h5A, "R8 low byte of combined load");
        rd(REG_HI, 8'hC3, "R8 high byte of combined load");

        // rollover
        wr(REG_HI, 8'hFF);
        wr(REG_LO, 8'hFD);
        count_en = 1'b1;
        @(negedge clk); chk_bit("R3 no pulse at 0xFFFE", wrap_pulse, 1'b0);
        @(negedge clk); chk_bit("R3 no pulse at 0xFFFF", wrap_pulse, 1'b0);
        @(negedge clk); chk_bit("R3 pulse after wrap",   wrap_pulse, 1'b1);
        @(negedge clk); chk_bit("R3 pulse lasts one cycle", wrap_pulse, 1'b0);
        count_en = 1'b0;
        rd(REG_LO, 8'h01, "R3 count after wrap low");
        rd(REG_HI, 8'h00, "R3 count after wrap high");

        // write beats increment, buffered
        count_en = 1'b1;
        wr(REG_LO, 8'h10);
        count_en = 1'b0;
        rd(REG_LO, 8'h10, "R9 buffered load not advanced");
        rd(REG_HI, 8'h00, "R9 buffered load high");

        // write beats increment, direct
        wr(REG_CTL, 8'h00);
        count_en = 1'b1;
        wr(REG_HI, 8'h22);
        count_en = 1'b0;
        rd(REG_LO, 8'h10, "R9 direct high write freezes low");
        rd(REG_HI, 8'h22, "R9 direct high write value");

        // unused address
        wr(2'd3, 8'h77);
        rd(2'd3,   8'h00, "R10 unused address reads zero");
        rd(REG_CTL, 8'h00, "R10 control untouched");
        rd(REG_LO, 8'h10, "R10 low untouched");
        rd(REG_HI, 8'h22, "R10 high untouched");

        idle(2);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: %0d results missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule